// File: doc/BRIEF.md
# Dual-Channel Read Address Pointer

This block produces the read addresses for a two-channel frame-buffer FIFO. Each channel has a 24-bit pointer on a shared read clock. When a channel's active-low read enable is LOW, its pointer steps forward by one on each clock. It wraps from the top address back to zero.

Two shared strobes override the stepping. One active-low clear zeroes the pointers. One active-low set loads a 24-bit external address. Each strobe is either level-sensitive or acts only on its falling edge. A select pin picks the mode of the set strobe, and per-strobe override bits can take priority over it. The clear acts on a channel only if that channel's enable was LOW on the previous clock.

Top module: `frame_rd_pointer`

## Requirements
- R1: A synchronous active-high reset sets both pointers to 0. It also returns the edge-detect history and the previous-enable history to the inactive (HIGH) level.
- R2: When the clear and set are not in effect and a channel's enable `rdEnN[c]` is 0, that pointer rises by one per clock. It wraps from 0xFFFFFF to 0.
- R3: In level clear mode, `clrN` = 0 at a clock edge zeroes every qualifying pointer. The pointer stays at 0 for every clock that `clrN` remains 0.
- R4: In edge clear mode, only a 1-to-0 transition of `clrN` between two clock edges zeroes the pointer. The pointer is zeroed once, and stepping resumes on the next clock even though `clrN` stays 0.
- R5: A clear affects channel c only if `rdEnN[c]` was 0 at the previous clock edge. The single `clrN` pin serves both channels.
- R6: The set mode comes from `ovrMode[1]` (1 = edge) when `ovrEn[1]` is 1. Otherwise `edgeSel` = 0 selects level and `edgeSel` = 1 selects edge.
- R7: An active set loads `loadAddr` into each channel whose `rdEnN[c]` is 0 at that edge. In level mode the load repeats on every clock while `setN` is 0. In edge mode it happens once per falling edge.
- R8: The priority is clear, then set, then increment.
- R9: A channel whose `rdEnN[c]` is 1 keeps its pointer unchanged unless a qualifying clear applies to it.
- R10: The clear mode comes from `ovrMode[0]` (1 = edge) when `ovrEn[0]` is 1. Otherwise the clear is level-sensitive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst | input | 1 | Synchronous reset, active high |
| rdEnN | input | 2 | Per-channel read enable, active low |
| clrN | input | 1 | Shared pointer clear, active low |
| setN | input | 1 | Shared pointer load strobe, active low |
| loadAddr | input | 24 | Address loaded by the set strobe |
| edgeSel | input | 1 | Default set-strobe mode: 0 level, 1 edge |
| ovrEn | input | 2 | Mode override enable: bit 0 clear, bit 1 set |
| ovrMode | input | 2 | Override mode when enabled (1 = edge): bit 0 clear, bit 1 set |
| rdAddr0 | output | 24 | Channel 0 read address |
| rdAddr1 | output | 24 | Channel 1 read address |

## Verification
The assertions assume that the mode inputs (`edgeSel`, `ovrEn`, `ovrMode`) are stable for at least one clock before a strobe is judged. The edge-mode checks compare the current strobe level with its level one clock earlier. The properties that depend on history are gated until one full clock after reset. This keeps values driven during reset from being read as edges or as prior enables. The stimulus changes mode inputs only while both strobes are HIGH, and it drives every input half a period away from the active edge.

// File: rtl/frame_rd_pointer_pkg.sv
package frame_rd_pointer_pkg;
  localparam int NumCh = 2;

  typedef struct packed {
    logic [NumCh-1:0] clr;
    logic [NumCh-1:0] load;
    logic [NumCh-1:0] inc;
  } ptrStrobes_t;
endpackage

// File: rtl/frame_rd_pointer_ctrl.sv
module frame_rd_pointer_ctrl
  import frame_rd_pointer_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NumCh-1:0] rdEnN,
  input  logic             clrN,
  input  logic             setN,
  input  logic             edgeSel,
  input  logic [1:0]       ovrEn,
  input  logic [1:0]       ovrMode,
  output ptrStrobes_t      strb
);
  logic             clrPrevQ;
  logic             setPrevQ;
  logic [NumCh-1:0] enPrevQ;
  logic             clrEdgeMode;
  logic             setEdgeMode;
  logic             clrFire;
  logic             setFire;

  always_ff @(posedge clk) begin
    if (rst) begin
      clrPrevQ <= 1'b1;
      setPrevQ <= 1'b1;
      enPrevQ  <= '1;
    end else begin
      clrPrevQ <= clrN;
      setPrevQ <= setN;
      enPrevQ  <= rdEnN;
    end
  end

  // Mode selection: clear defaults to level, set follows edgeSel (R6, R10)
  always_comb begin
    clrEdgeMode = ovrEn[0] & ovrMode[0];
    setEdgeMode = ovrEn[1] ? ovrMode[1] : edgeSel;
    clrFire     = clrEdgeMode ? (clrPrevQ & ~clrN) : ~clrN;
    setFire     = setEdgeMode ? (setPrevQ & ~setN) : ~setN;
  end

  // Per-channel strobes with priority clear > set > increment (R8)
  for (genvar c = 0; c < NumCh; c++) begin : g_ch
    always_comb begin
      strb.clr[c]  = clrFire & ~enPrevQ[c];
      strb.load[c] = ~strb.clr[c] & setFire & ~rdEnN[c];
      strb.inc[c]  = ~strb.clr[c] & ~strb.load[c] & ~rdEnN[c];
    end
  end
endmodule

// File: rtl/frame_rd_pointer_dp.sv
module frame_rd_pointer_dp
  import frame_rd_pointer_pkg::*;
#(
  parameter int AddrW = 24
) (
  input  logic                        clk,
  input  logic                        rst,
  input  ptrStrobes_t                 strb,
  input  logic [AddrW-1:0]            loadAddr,
  output logic [NumCh-1:0][AddrW-1:0] ptr
);
  for (genvar c = 0; c < NumCh; c++) begin : g_ptr
    logic [AddrW-1:0] ptrQ;

    always_ff @(posedge clk) begin
      if (rst)               ptrQ <= '0;
      else if (strb.clr[c])  ptrQ <= '0;
      else if (strb.load[c]) ptrQ <= loadAddr;
      else if (strb.inc[c])  ptrQ <= ptrQ + AddrW'(1);
    end

    assign ptr[c] = ptrQ;
  end
endmodule

// File: rtl/frame_rd_pointer.sv
module frame_rd_pointer
  import frame_rd_pointer_pkg::*;
#(
  parameter int AddrW = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       rdEnN,
  input  logic             clrN,
  input  logic             setN,
  input  logic [AddrW-1:0] loadAddr,
  input  logic             edgeSel,
  input  logic [1:0]       ovrEn,
  input  logic [1:0]       ovrMode,
  output logic [AddrW-1:0] rdAddr0,
  output logic [AddrW-1:0] rdAddr1
);
  ptrStrobes_t                 strb;
  logic [NumCh-1:0][AddrW-1:0] ptr;

  frame_rd_pointer_ctrl i_ctrl (
    .clk(clk), .rst(rst), .rdEnN(rdEnN), .clrN(clrN), .setN(setN),
    .edgeSel(edgeSel), .ovrEn(ovrEn), .ovrMode(ovrMode), .strb(strb)
  );

  frame_rd_pointer_dp #(.AddrW(AddrW)) i_dp (
    .clk(clk), .rst(rst), .strb(strb), .loadAddr(loadAddr), .ptr(ptr)
  );

  assign rdAddr0 = ptr[0];
  assign rdAddr1 = ptr[1];
endmodule

// File: rtl/frame_rd_pointer_checker.sv
module frame_rd_pointer_checker #(
  parameter int AddrW = 24
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       rdEnN,
  input logic             clrN,
  input logic             setN,
  input logic [AddrW-1:0] loadAddr,
  input logic             edgeSel,
  input logic [1:0]       ovrEn,
  input logic [1:0]       ovrMode,
  input logic [AddrW-1:0] rdAddr0,
  input logic [AddrW-1:0] rdAddr1
);
  logic seenQ;
  always_ff @(posedge clk) seenQ <= ~rst;

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (clrN && setN && !rdEnN[0]) |=> rdAddr0 == $past(rdAddr0) + AddrW'(1));

  p_level_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (seenQ && !clrN && !ovrEn[0] && !$past(rdEnN[0])) |=> rdAddr0 == '0);

  p_edge_clear_once_r4: assert property (@(posedge clk) disable iff (rst)
    (seenQ && ovrEn[0] && ovrMode[0] && !clrN && !$past(clrN) && setN && !rdEnN[1])
      |=> rdAddr1 == $past(rdAddr1) + AddrW'(1));

  p_level_set_r7: assert property (@(posedge clk) disable iff (rst)
    (clrN && !setN && (ovrEn[1] ? !ovrMode[1] : !edgeSel) && !rdEnN[0])
      |=> rdAddr0 == $past(loadAddr));

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (clrN && setN && rdEnN[1]) |=> $stable(rdAddr1));
endmodule

bind frame_rd_pointer frame_rd_pointer_checker #(.AddrW(AddrW)) i_chk (.*);

// File: tb/test_frame_rd_pointer.sv
module test_frame_rd_pointer;
  typedef struct {
    logic [23:0] a0;
    logic [23:0] a1;
    string       tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  rdEnN = 2'b11;
  logic        clrN = 1'b1;
  logic        setN = 1'b1;
  logic [23:0] loadAddr = '0;
  logic        edgeSel = 1'b0;
  logic [1:0]  ovrEn = 2'b00;
  logic [1:0]  ovrMode = 2'b00;
  logic [23:0] rdAddr0;
  logic [23:0] rdAddr1;

  expItem_t    expQ[$];
  int          nCmp = 0;
  int          nBad = 0;
  bit          done = 1'b0;

  logic [23:0] mA[2];
  logic        mClrPrev, mSetPrev;
  logic [1:0]  mEnPrev;

  frame_rd_pointer i_frame_rd_pointer (.*);

  always #5 clk = ~clk;

  // Driver: apply one cycle of stimulus and predict the result
  task automatic drive(input logic r, input logic [1:0] en, input logic c,
                       input logic s, input logic [23:0] a, input string tag);
    logic clrEdge, setEdge, clrAct, setAct;
    expItem_t it;
    @(negedge clk);
    rst = r; rdEnN = en; clrN = c; setN = s; loadAddr = a;
    if (r) begin
      mA[0] = '0; mA[1] = '0;
      mClrPrev = 1'b1; mSetPrev = 1'b1; mEnPrev = 2'b11;
    end else begin
      clrEdge = ovrEn[0] & ovrMode[0];
      setEdge = ovrEn[1] ? ovrMode[1] : edgeSel;
      clrAct  = clrEdge ? (mClrPrev & ~c) : ~c;
      setAct  = setEdge ? (mSetPrev & ~s) : ~s;
      for (int ch = 0; ch < 2; ch++) begin
        if (clrAct && !mEnPrev[ch])   mA[ch] = '0;
        else if (setAct && !en[ch])   mA[ch] = a;
        else if (!en[ch])             mA[ch] = mA[ch] + 24'd1;
      end
      mClrPrev = c; mSetPrev = s; mEnPrev = en;
    end
    it.a0 = mA[0]; it.a1 = mA[1]; it.tag = tag;
    expQ.push_back(it);
  endtask

  // Monitor: compare after each active edge
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      nCmp++;
      if (rdAddr0 !== it.a0 || rdAddr1 !== it.a1) begin
        nBad++;
        $display("FAIL %s: actual %h/%h expected %h/%h",
                 it.tag, rdAddr0, rdAddr1, it.a0, it.a1);
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    drive(1, 2'b11, 1, 1, '0, "R1 reset");
    drive(1, 2'b00, 0, 0, 24'h55, "R1 reset");
    repeat (5) drive(0, 2'b00, 1, 1, '0, "R2 step");
    repeat (3) drive(0, 2'b10, 1, 1, '0, "R9 hold ch1");
    drive(0, 2'b00, 1, 1, '0, "R2 step");
    repeat (3) drive(0, 2'b00, 0, 1, '0, "R3 level clear");
    drive(0, 2'b00, 1, 1, '0, "R2 resume");
    drive(0, 2'b10, 1, 1, '0, "R5 prep");
    drive(0, 2'b00, 0, 1, '0, "R5 ch1 not qualified");
    drive(0, 2'b00, 0, 1, '0, "R5 both cleared");
    drive(0, 2'b00, 1, 1, '0, "R2 step");
    ovrEn = 2'b01; ovrMode = 2'b01;
    drive(0, 2'b00, 1, 1, '0, "R10 mode change");
    repeat (3) drive(0, 2'b00, 0, 1, '0, "R4 edge clear once");
    drive(0, 2'b00, 1, 1, '0, "R4 release");
    ovrEn = 2'b00; ovrMode = 2'b00; edgeSel = 1'b0;
    drive(0, 2'b00, 1, 1, '0, "R6 level set prep");
    drive(0, 2'b00, 1, 0, 24'h123456, "R7 level set");
    drive(0, 2'b00, 1, 0, 24'h00abcd, "R7 level set repeat");
    drive(0, 2'b00, 1, 1, '0, "R2 step");
    edgeSel = 1'b1;
    drive(0, 2'b00, 1, 1, '0, "R6 edge prep");
    repeat (3) drive(0, 2'b00, 1, 0, 24'h400000, "R6 edge set");
    drive(0, 2'b00, 1, 1, '0, "R6 release");
    ovrEn = 2'b10; ovrMode = 2'b00;
    drive(0, 2'b00, 1, 1, '0, "R6 override prep");
    repeat (2) drive(0, 2'b00, 1, 0, 24'h000777, "R6 override level set");
    drive(0, 2'b00, 1, 1, '0, "R2 step");
    ovrEn = 2'b00; edgeSel = 1'b0;
    drive(0, 2'b00, 1, 1, '0, "R8 prep");
    drive(0, 2'b00, 0, 0, 24'h0f0f0f, "R8 clear beats set");
    drive(0, 2'b10, 1, 0, 24'hfffffe, "R7 set only enabled");
    drive(0, 2'b00, 1, 1, '0, "R2 near top");
    drive(0, 2'b00, 1, 1, '0, "R2 wrap");
    drive(0, 2'b00, 1, 1, '0, "R2 after wrap");
    drive(0, 2'b11, 0, 1, '0, "R5 disabled-now clear");
    drive(0, 2'b11, 1, 1, '0, "R9 hold both");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule